// File: doc/BRIEF.md
# Two-Channel DMA Request Router and Handshake

This block sits in front of the address and bus sequencer of a two-channel DMA engine. For each channel it picks one hardware request out of a fixed, channel-specific set of on-chip peripheral flags, a timer output and an external request pin. It merges that request with a sticky software request and presents the result to the sequencer as `req_out`.

The sequencer answers with a one-cycle `grant`. From the next cycle the channel holds its active-low acknowledge asserted until the sequencer reports `xfer_done`, or until a terminate arrives on the shared end-of-process line.

The end-of-process line is open-drain and is shared by both channels. The block reads the line through `eop_line`, and pulls it low for one clock through `eop_pull` when a transfer completes. Its own pull is masked, so it is never mistaken for an external terminate. The external request pins and the end-of-process input cross into the clock domain through two-flop synchronizers. Arbitration between the channels, address counting and bus cycles belong to the sequencer.

Top module: `dmarq_route`

## Requirements
- R1: With `src_sel_ch0` = 0..7, channel 0's hardware request is, in order: `periph_req[0]` (serial port 0 receive), `periph_req[1]` (serial port 0 transmit), `periph_req[2]` (serial port 1 receive), `periph_req[3]` (serial port 1 transmit), `periph_req[4]` (synchronous serial transmit), `periph_req[5]` (synchronous serial receive), `tmr_req[0]`, and `ext_req[0]`. No other input reaches channel 0.
- R2: With `src_sel_ch1` = 0..7, channel 1's hardware request is, in order: `periph_req[2]`, `periph_req[3]`, `periph_req[1]`, `periph_req[0]`, `periph_req[5]`, `periph_req[4]`, `tmr_req[1]`, and `ext_req[1]`. No other input reaches channel 1.
- R3: A change on `ext_req[n]` reaches `req_out[n]` after exactly two rising clock edges. The peripheral and timer inputs reach it in the same cycle.
- R4: A clock edge with `sw_req_wr` high sets a pending software request for each channel whose bit in `sw_req_bits` is 1. The pending request is ORed with the hardware request and stays set until it is accepted.
- R5: The pending software request of a channel clears on the edge at which that channel's grant is accepted.
- R6: When a channel is idle, `req_out[n]` is high and `grant[n]` is high at an edge, `ack_n[n]` goes low after that edge. `ack_n[n]` then stays low until the transfer ends. `req_out[n]` is low while the channel is active.
- R7: A `grant[n]` given while `req_out[n]` is low has no effect: `ack_n[n]` stays high. An `xfer_done[n]` given while the channel is idle produces no `eop_pull`.
- R8: `xfer_done[n]` high at an edge while the channel is active makes `ack_n[n]` go high after that edge. It also makes `eop_pull` high for exactly that one following cycle.
- R9: An external low on `eop_line` ends every active channel after three rising edges. Two of those edges are for synchronization and one is for the state update. The affected channels raise `ack_n` and pulse `term_o` for one cycle, with no `eop_pull`.
- R10: The line's low level caused by the block's own `eop_pull` does not terminate the other active channel.
- R11: After reset, `ack_n` is 2'b11, and `req_out`, `eop_pull` and `term_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_req | input | 6 | On-chip peripheral request flags (serial 0 rx/tx, serial 1 rx/tx, sync serial tx/rx) |
| tmr_req | input | 2 | Timer outputs; bit n feeds channel n |
| ext_req | input | 2 | Asynchronous external request pins, one per channel |
| src_sel_ch0 | input | 3 | Hardware source select for channel 0 |
| src_sel_ch1 | input | 3 | Hardware source select for channel 1 |
| sw_req_wr | input | 1 | Software request register write strobe |
| sw_req_bits | input | 2 | Software request write data, bit n for channel n |
| grant | input | 2 | Sequencer grant, one pulse per channel |
| xfer_done | input | 2 | Sequencer transfer complete, per channel |
| eop_line | input | 1 | Level sampled from the shared end-of-process line (low = asserted) |
| req_out | output | 2 | Request to the sequencer, per channel |
| ack_n | output | 2 | Active-low acknowledge, per channel |
| eop_pull | output | 1 | Open-drain enable: 1 pulls the end-of-process line low |
| term_o | output | 2 | One-cycle pulse when a channel was ended by an external terminate |

## Verification
Every source-select value of each channel is swept against a single active source drawn from all ten candidate inputs. This includes the other channel's timer and pin, so the sweep separates a correct cross-wiring from a swapped, shifted or leaking one.

The external pin is also stepped edge by edge, which separates a two-stage synchronizer from a shorter or longer one. Handshake runs compare software-only, grant-without-request and done-while-idle patterns, and an edge-by-edge external terminate checks the synchronizer delay on the end-of-process input. A completion on one channel while the other is still busy separates a masked self-pull from one that wrongly ends both transfers.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
    localparam int NCH      = 2;
    localparam int N_PERIPH = 6;
    localparam int SEL_W    = 3;
    localparam int N_SRC    = 1 << SEL_W;

    // peripheral flag positions on periph_req
    localparam int P_SP0_RX = 0;
    localparam int P_SP0_TX = 1;
    localparam int P_SP1_RX = 2;
    localparam int P_SP1_TX = 3;
    localparam int P_SS_TX  = 4;
    localparam int P_SS_RX  = 5;

    typedef struct packed {
        logic active;   // channel acknowledged and in service
        logic sw_pend;  // sticky software request
        logic fin;      // completion pulse (drives the line pull)
        logic term;     // external-terminate pulse
    } chan_st_t;
endpackage

// File: rtl/dmarq_sync.sv
module dmarq_sync #(
    parameter int       W      = 1,
    parameter int       STAGES = 2,
    parameter logic     RST_V  = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {(STAGES*W){RST_V}};
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/dmarq_src_mux.sv
module dmarq_src_mux
    import dmarq_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic [N_PERIPH-1:0] periph,
    input  logic                tmr,
    input  logic                drq,
    input  logic [SEL_W-1:0]    sel,
    output logic                hw_req
);
    logic [N_SRC-1:0] src_vec;

    generate
        if (CH == 0) begin : g_ch0
            assign src_vec = {drq, tmr,
                              periph[P_SS_RX],  periph[P_SS_TX],
                              periph[P_SP1_TX], periph[P_SP1_RX],
                              periph[P_SP0_TX], periph[P_SP0_RX]};
        end else begin : g_ch1
            assign src_vec = {drq, tmr,
                              periph[P_SS_TX],  periph[P_SS_RX],
                              periph[P_SP0_RX], periph[P_SP0_TX],
                              periph[P_SP1_TX], periph[P_SP1_RX]};
        end
    endgenerate

    assign hw_req = src_vec[sel];
endmodule

// File: rtl/dmarq_chan.sv
module dmarq_chan
    import dmarq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_req,
    input  logic sw_set,
    input  logic grant,
    input  logic done,
    input  logic ext_term,
    output logic req,
    output logic ack_n,
    output logic fin,
    output logic term
);
    chan_st_t st_d, st_q;
    logic     start;

    always_comb begin
        st_d   = st_q;
        req    = (hw_req | st_q.sw_pend) & ~st_q.active;
        start  = req & grant;
        st_d.sw_pend = (st_q.sw_pend & ~start) | sw_set;
        st_d.fin  = 1'b0;
        st_d.term = 1'b0;
        if (start) begin
            st_d.active = 1'b1;
        end else if (st_q.active) begin
            if (done) begin
                st_d.active = 1'b0;
                st_d.fin    = 1'b1;
            end else if (ext_term) begin
                st_d.active = 1'b0;
                st_d.term   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_n = ~st_q.active;
    assign fin   = st_q.fin;
    assign term  = st_q.term;
endmodule

// File: rtl/dmarq_route.sv
module dmarq_route
    import dmarq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PERIPH-1:0] periph_req,
    input  logic [NCH-1:0]      tmr_req,
    input  logic [NCH-1:0]      ext_req,
    input  logic [SEL_W-1:0]    src_sel_ch0,
    input  logic [SEL_W-1:0]    src_sel_ch1,
    input  logic                sw_req_wr,
    input  logic [NCH-1:0]      sw_req_bits,
    input  logic [NCH-1:0]      grant,
    input  logic [NCH-1:0]      xfer_done,
    input  logic                eop_line,
    output logic [NCH-1:0]      req_out,
    output logic [NCH-1:0]      ack_n,
    output logic                eop_pull,
    output logic [NCH-1:0]      term_o
);
    logic [NCH-1:0]       drq_s;
    logic                 eop_s;
    logic [NCH-1:0]       fin;
    logic [NCH-1:0][SEL_W-1:0] sel;
    logic [SYNC_STAGES-1:0] mask_d, mask_q;
    logic                 ext_term;

    assign sel[0] = src_sel_ch0;
    assign sel[1] = src_sel_ch1;

    dmarq_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_V(1'b0)) u_drq_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_req), .dout(drq_s)
    );

    dmarq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_eop_sync (
        .clk(clk), .rst_n(rst_n), .din(eop_line), .dout(eop_s)
    );

    // own-pull mask travels alongside the line through the synchronizer
    always_comb begin
        mask_d = {mask_q[SYNC_STAGES-2:0], eop_pull};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign ext_term = ~eop_s & ~mask_q[SYNC_STAGES-1];

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic hw;
            dmarq_src_mux #(.CH(c)) u_mux (
                .periph(periph_req), .tmr(tmr_req[c]), .drq(drq_s[c]),
                .sel(sel[c]), .hw_req(hw)
            );
            dmarq_chan u_chan (
                .clk(clk), .rst_n(rst_n), .hw_req(hw),
                .sw_set(sw_req_wr & sw_req_bits[c]),
                .grant(grant[c]), .done(xfer_done[c]), .ext_term(ext_term),
                .req(req_out[c]), .ack_n(ack_n[c]),
                .fin(fin[c]), .term(term_o[c])
            );
        end
    endgenerate

    assign eop_pull = |fin;
endmodule

// File: rtl/dmarq_route_chk.sv
module dmarq_route_chk
    import dmarq_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] grant,
    input logic [NCH-1:0] xfer_done,
    input logic [NCH-1:0] req_out,
    input logic [NCH-1:0] ack_n,
    input logic           eop_pull,
    input logic [NCH-1:0] term_o
);
    p_eop_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pull |-> $past(|(xfer_done & ~ack_n)));

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_p
            p_grant_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_n[c] && req_out[c] && grant[c]) |=> !ack_n[c]);
            p_quiet_while_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !ack_n[c] |-> !req_out[c]);
            p_stray_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_n[c] && !req_out[c]) |=> ack_n[c]);
            p_done_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!ack_n[c] && xfer_done[c]) |=> (ack_n[c] && eop_pull));
            p_term_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
                term_o[c] |-> (ack_n[c] && $past(!ack_n[c])));
        end
    endgenerate
endmodule

bind dmarq_route dmarq_route_chk u_chk (
    .clk(clk), .rst_n(rst_n), .grant(grant), .xfer_done(xfer_done),
    .req_out(req_out), .ack_n(ack_n), .eop_pull(eop_pull), .term_o(term_o)
);

// File: tb/tb_dmarq_route.sv
`timescale 1ns/1ps
module tb_dmarq_route;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] periph_req = '0;
    logic [1:0] tmr_req = '0, ext_req = '0;
    logic [2:0] src_sel_ch0 = '0, src_sel_ch1 = '0;
    logic       sw_req_wr = 1'b0;
    logic [1:0] sw_req_bits = '0, grant = '0, xfer_done = '0;
    logic       ext_eop = 1'b0;
    logic       eop_line;
    logic [1:0] req_out, ack_n, term_o;
    logic       eop_pull;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    // open-drain pad: low when the block or the outside pulls
    assign eop_line = ~(eop_pull | ext_eop);

    dmarq_route dut (.*);

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int src_id(int ch, int s);
        int m0[8] = '{0, 1, 2, 3, 4, 5, 6, 7};
        int m1[8] = '{2, 3, 1, 0, 5, 4, 6, 7};
        return (ch == 0) ? m0[s] : m1[s];
    endfunction

    // stimulus id: 0..5 periph bit, 6 own timer, 7 own pin, 8 other timer, 9 other pin
    task automatic drive_src(int ch, int s);
        periph_req = '0; tmr_req = '0; ext_req = '0;
        if (s < 6)       periph_req[s] = 1'b1;
        else if (s == 6) tmr_req[ch] = 1'b1;
        else if (s == 7) ext_req[ch] = 1'b1;
        else if (s == 8) tmr_req[1-ch] = 1'b1;
        else             ext_req[1-ch] = 1'b1;
    endtask

    task automatic pulse_grant(int ch);
        grant[ch] = 1'b1; step(); grant = '0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(2);
        // R11 reset state
        chk("R11 ack_n", ack_n, 2'b11);
        chk("R11 req_out", req_out, 0);
        chk("R11 eop_pull", eop_pull, 0);
        chk("R11 term_o", term_o, 0);
        rst_n = 1'b1;
        step();

        // R1 / R2 sweep of every select against every candidate source
        for (int ch = 0; ch < 2; ch++) begin
            for (int sel = 0; sel < 8; sel++) begin
                src_sel_ch0 = 3'(sel); src_sel_ch1 = 3'(sel);
                for (int s = 0; s < 10; s++) begin
                    drive_src(ch, s);
                    step(3);
                    chk(ch == 0 ? "R1 route" : "R2 route",
                        req_out[ch], (s == src_id(ch, sel)) ? 1 : 0);
                    drive_src(ch, 0); periph_req = '0;
                    step(3);
                end
            end
        end

        // R3 pin synchronizer latency
        src_sel_ch0 = 3'd7;
        ext_req[0] = 1'b1;
        step();
        chk("R3 after one edge", req_out[0], 0);
        step();
        chk("R3 after two edges", req_out[0], 1);
        ext_req[0] = 1'b0;
        step(3);
        src_sel_ch0 = 3'd0;
        periph_req[0] = 1'b1; #1;
        chk("R3 periph same cycle", req_out[0], 1);
        periph_req = '0;
        step();

        // R7 stray grant and stray done
        pulse_grant(0);
        chk("R7 grant ignored", ack_n[0], 1);
        xfer_done[1] = 1'b1; step(); xfer_done = '0;
        chk("R7 done ignored", eop_pull, 0);

        // R4 software request, sticky
        sw_req_bits = 2'b01; sw_req_wr = 1'b1; step(); sw_req_wr = 1'b0;
        chk("R4 sw set", req_out, 2'b01);
        step(5);
        chk("R4 sw sticky", req_out[0], 1);

        // R6 grant accepted
        pulse_grant(0);
        chk("R6 ack asserted", ack_n, 2'b10);
        chk("R6 req low while active", req_out[0], 0);
        step(4);
        chk("R6 ack held", ack_n[0], 0);

        // R8 completion
        xfer_done[0] = 1'b1; step(); xfer_done = '0;
        chk("R8 ack released", ack_n[0], 1);
        chk("R8 eop pull", eop_pull, 1);
        step();
        chk("R8 eop one cycle", eop_pull, 0);
        // R5 software request was consumed at grant
        chk("R5 sw cleared", req_out[0], 0);

        // R9 external terminate on both channels
        periph_req[0] = 1'b1; src_sel_ch0 = 3'd0; src_sel_ch1 = 3'd3;
        #1;
        grant = 2'b11; step(); grant = '0;
        periph_req = '0;
        chk("R9 both active", ack_n, 2'b00);
        ext_eop = 1'b1; step(); ext_eop = 1'b0;
        chk("R9 still active edge1", ack_n, 2'b00);
        step();
        chk("R9 still active edge2", ack_n, 2'b00);
        step();
        chk("R9 released edge3", ack_n, 2'b11);
        chk("R9 term pulse", term_o, 2'b11);
        chk("R9 no pull", eop_pull, 0);
        step();
        chk("R9 term one cycle", term_o, 0);

        // R10 own pull does not end the other channel
        periph_req[0] = 1'b1; #1;
        grant = 2'b11; step(); grant = '0;
        periph_req = '0;
        xfer_done[0] = 1'b1; step(); xfer_done = '0;
        chk("R10 pull", eop_pull, 1);
        step(5);
        chk("R10 other still active", ack_n, 2'b01);
        chk("R10 no term", term_o, 0);
        xfer_done[1] = 1'b1; step(); xfer_done = '0;
        chk("R10 ch1 done", ack_n, 2'b11);
        step(4);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule